// File: doc/BRIEF.md
# Synthesizer Loop Calibration Sequencer

This block decides when the oscillator of a clock synthesizer may run from its normal control loop and when it must be recalibrated. Four request inputs can start a calibration: a power-on request, a soft-reset request, a loss of the reference signal and a loss of lock. Leaving reset also counts as a power-on event, so the oscillator is always calibrated before normal operation begins.

While a calibration runs, the sequencer drives the oscillator tuning word itself. It holds every output clock enable low and forces the lock alarm inactive. The search steps a tuning code upward from zero until a "tuned" comparator input reports a match. A programmable settle interval follows. The block then hands the tuning word back to the loop, enables the clocks and emits a one-cycle completion pulse.

Requests that arrive in the middle of a calibration collapse into a single pending flag, which buys exactly one further pass. If no code matches, a failure flag holds the outputs off until a new request arrives.

Top module: `pll_cal_seq`

## Requirements
- R1: While `rst_n` is low, `clk_en` is all zeros and `cal_done`, `cal_fail` and `lol_alarm` are 0. After `rst_n` is released, a calibration starts without any request input.
- R2: The sweep presents tuning codes 0, 1, 2, ... on `vco_code`, one code per cycle. It stops at the first code T for which `tuned` is high and holds T on `vco_code` until the calibration ends.
- R3: Count from the clock edge that first sees a request (or the first edge with `rst_n` high). `cal_done` goes high 4 + T + S cycles later, where S is `settle_len`.
- R4: While `cal_active` is 1, `clk_en` is all zeros and `lol_alarm` is 0. This holds even when `lock_lost` is high.
- R5: In normal operation, `clk_en` is all ones, `vco_code` equals `loop_code` and `lol_alarm` follows `lock_lost`.
- R6: `cal_done` is a single-cycle pulse issued on entry to normal operation.
- R7: In normal operation, a rising edge on any of `por_req`, `soft_req`, `sig_lost` or `lock_lost` restarts calibration on the next edge.
- R8: During a calibration, rising edges on `por_req`, `soft_req` or `sig_lost` set one pending flag. Any number of such edges yields exactly one further calibration, which starts directly after the current one ends. The single `cal_done` then arrives 7 + 2T + 2S cycles after the first request.
- R9: A rising edge on `lock_lost` during a calibration does not request another calibration.
- R10: If code 255 is reached without `tuned`, `cal_fail` goes high 258 cycles after the request. The block then stays with `clk_en` at zero and `cal_active` at 0, and `lock_lost` edges are ignored. A rising edge on `por_req`, `soft_req` or `sig_lost` clears `cal_fail` and restarts calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_req | input | 1 | Power-on calibration request (edge) |
| soft_req | input | 1 | Soft-reset calibration request (edge) |
| sig_lost | input | 1 | Reference signal lost (edge) |
| lock_lost | input | 1 | Raw loss-of-lock indication |
| tuned | input | 1 | Comparator: current tuning code is adequate |
| loop_code | input | CODE_W | Tuning word from the normal loop |
| settle_len | input | SETTLE_W | Settle interval S in cycles |
| vco_code | output | CODE_W | Tuning word applied to the oscillator |
| clk_en | output | N_CLK | Output clock enables |
| lol_alarm | output | 1 | Masked loss-of-lock alarm |
| cal_active | output | 1 | Calibration in progress |
| cal_done | output | 1 | One-cycle calibration-complete pulse |
| cal_fail | output | 1 | Sweep found no matching code |

## Verification
The properties assume that `tuned` is a function of the applied tuning code, and that `settle_len` and `loop_code` do not change while a calibration runs. The stimulus meets both assumptions. It models the comparator as "code at or above a threshold". It changes the threshold and the settle length only in normal operation or in the failed state, and it drives request pulses at falling edges. Loss-of-lock is deliberately held high through a calibration to show the masking, since a real loop loses lock while it is being retuned.

// File: rtl/pcs_pkg.sv
// Shared definitions for the calibration sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package pcs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_SWEEP  = 3'd2,
        ST_SETTLE = 3'd3,
        ST_RUN    = 3'd4
    } cal_state_t;

    localparam int unsigned EVT_POR  = 0;
    localparam int unsigned EVT_SOFT = 1;
    localparam int unsigned EVT_LOS  = 2;
    localparam int unsigned EVT_LOL  = 3;
    localparam int unsigned N_EVT    = 4;
endpackage

// File: rtl/pcs_edge_detect.sv
// Rising-edge detector for a vector of request lines.
// Assumes: inputs are synchronous to clk; the history register clears on reset.
module pcs_edge_detect #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] hist_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Remember each line's previous level.
        always_ff @(posedge clk) begin
            if (!rst_n) hist_q[i] <= 1'b0;
            else        hist_q[i] <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~hist_q[i];
    end
endmodule

// File: rtl/pcs_sweep.sv
// Tuning-code counter used by the calibration search.
// Assumes: load and step are never asserted together.
module pcs_sweep #(
    parameter int unsigned CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_zero,
    input  logic              step,
    output logic [CODE_W-1:0] code,
    output logic              at_max
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    // Restart from zero or advance by one code.
    always_ff @(posedge clk) begin
        if (!rst_n)         code <= '0;
        else if (load_zero) code <= '0;
        else if (step)      code <= code + 1'b1;
    end

    assign at_max = (code == CODE_MAX);
endmodule

// File: rtl/pcs_settle.sv
// Settle-interval counter: expired is high once count equals limit.
// Assumes: limit is stable while clear is low.
module pcs_settle #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Count cycles spent in the settle phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (!expired)   cnt_q <= cnt_q + 1'b1;
    end

    assign expired = !clear && (cnt_q == limit);
endmodule

// File: rtl/pll_cal_seq.sv
// Calibration sequencer for a synthesizer oscillator.
// Owns the tuning word during calibration, gates the output clocks and
// masks the lock alarm, and collapses requests that arrive mid-calibration
// into one pending pass.
// Assumes: tuned depends only on vco_code; settle_len and loop_code are
// stable during a calibration.
module pll_cal_seq
    import pcs_pkg::*;
#(
    parameter int unsigned CODE_W   = 8,
    parameter int unsigned SETTLE_W = 16,
    parameter int unsigned N_CLK    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                por_req,
    input  logic                soft_req,
    input  logic                sig_lost,
    input  logic                lock_lost,
    input  logic                tuned,
    input  logic [CODE_W-1:0]   loop_code,
    input  logic [SETTLE_W-1:0] settle_len,
    output logic [CODE_W-1:0]   vco_code,
    output logic [N_CLK-1:0]    clk_en,
    output logic                lol_alarm,
    output logic                cal_active,
    output logic                cal_done,
    output logic                cal_fail
);
    cal_state_t        state_q, state_d;
    logic              pend_q, pend_d;
    logic              fail_q, fail_d;
    logic              done_q, done_d;
    logic              ld_code, step_code, at_max, settled;
    logic [CODE_W-1:0] sweep_code;
    logic [N_EVT-1:0]  evt_lvl, evt_rise;
    logic              trig_cal, trig_any, in_run;

    assign evt_lvl[EVT_POR]  = por_req;
    assign evt_lvl[EVT_SOFT] = soft_req;
    assign evt_lvl[EVT_LOS]  = sig_lost;
    assign evt_lvl[EVT_LOL]  = lock_lost;

    pcs_edge_detect #(.N(N_EVT)) u_edges (
        .clk(clk), .rst_n(rst_n), .lvl(evt_lvl), .rise(evt_rise)
    );

    pcs_sweep #(.CODE_W(CODE_W)) u_sweep (
        .clk(clk), .rst_n(rst_n), .load_zero(ld_code), .step(step_code),
        .code(sweep_code), .at_max(at_max)
    );

    pcs_settle #(.CNT_W(SETTLE_W)) u_settle (
        .clk(clk), .rst_n(rst_n), .clear(state_q != ST_SETTLE),
        .limit(settle_len), .expired(settled)
    );

    // Loss of lock is meaningless while retuning, so it only restarts from RUN.
    assign trig_cal = evt_rise[EVT_POR] | evt_rise[EVT_SOFT] | evt_rise[EVT_LOS];
    assign trig_any = trig_cal | evt_rise[EVT_LOL];

    // Next-state and control decode.
    always_comb begin
        state_d   = state_q;
        pend_d    = pend_q;
        fail_d    = fail_q;
        done_d    = 1'b0;
        ld_code   = 1'b0;
        step_code = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!fail_q || trig_cal) begin
                    state_d = ST_START;
                    fail_d  = 1'b0;
                end
            end
            ST_START: begin
                ld_code = 1'b1;
                state_d = ST_SWEEP;
                if (trig_cal) pend_d = 1'b1;
            end
            ST_SWEEP: begin
                if (trig_cal) pend_d = 1'b1;
                if (tuned) begin
                    state_d = ST_SETTLE;
                end else if (at_max) begin
                    state_d = ST_IDLE;
                    fail_d  = 1'b1;
                    pend_d  = 1'b0;
                end else begin
                    step_code = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (trig_cal) pend_d = 1'b1;
                if (settled) begin
                    if (pend_q || trig_cal) begin
                        state_d = ST_START;
                        pend_d  = 1'b0;
                    end else begin
                        state_d = ST_RUN;
                        done_d  = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (trig_any) state_d = ST_START;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, pending, failure and completion registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
            fail_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            fail_q  <= fail_d;
            done_q  <= done_d;
        end
    end

    assign in_run     = (state_q == ST_RUN);
    assign cal_active = (state_q == ST_START) || (state_q == ST_SWEEP) ||
                        (state_q == ST_SETTLE);
    assign clk_en     = {N_CLK{in_run}};
    assign lol_alarm  = lock_lost & in_run;
    assign vco_code   = in_run ? loop_code : sweep_code;
    assign cal_done   = done_q;
    assign cal_fail   = fail_q;
endmodule

// File: rtl/pll_cal_seq_chk.sv
// Property checker for the calibration sequencer, bound to every instance.
// Assumes: tuned depends only on vco_code; loop_code stable in normal operation.
module pll_cal_seq_chk #(
    parameter int unsigned CODE_W = 8,
    parameter int unsigned N_CLK  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_req,
    input logic              lock_lost,
    input logic [CODE_W-1:0] loop_code,
    input logic [CODE_W-1:0] vco_code,
    input logic [N_CLK-1:0]  clk_en,
    input logic              lol_alarm,
    input logic              cal_active,
    input logic              cal_done,
    input logic              cal_fail
);
    logic seen_q;

    // Marks that at least one cycle has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assert_code_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && cal_active && $past(cal_active) && vco_code != $past(vco_code))
        |-> (vco_code == $past(vco_code) + 1'b1 || vco_code == '0));

    assert_clk_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cal_active |-> (clk_en == '0));

    assert_alarm_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cal_active |-> !lol_alarm);

    assert_run_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (&clk_en) |-> (vco_code == loop_code && lol_alarm == lock_lost));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> !cal_done);

    assert_done_enters_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> (&clk_en));

    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && (&clk_en) && $rose(soft_req)) |=> cal_active);

    assert_fail_holds_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cal_fail |-> (clk_en == '0 && !cal_active));
endmodule

bind pll_cal_seq pll_cal_seq_chk #(.CODE_W(CODE_W), .N_CLK(N_CLK)) i_chk (
    .clk(clk), .rst_n(rst_n), .soft_req(soft_req), .lock_lost(lock_lost),
    .loop_code(loop_code), .vco_code(vco_code), .clk_en(clk_en),
    .lol_alarm(lol_alarm), .cal_active(cal_active), .cal_done(cal_done),
    .cal_fail(cal_fail)
);

// File: tb/test_pll_cal_seq.sv
module test_pll_cal_seq;
    localparam int CODE_W = 8;
    localparam int N_CLK  = 4;
    // Rows: threshold T, settle S, expected cycles to cal_done (4+T+S).
    localparam int NVEC = 6;
    localparam int VEC [NVEC][3] = '{
        '{0, 0, 4}, '{5, 3, 12}, '{17, 0, 21},
        '{255, 2, 261}, '{40, 100, 144}, '{1, 1, 6}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              por_req = 1'b0, soft_req = 1'b0, sig_lost = 1'b0, lock_lost = 1'b0;
    logic              tune_en = 1'b1;
    logic [7:0]        thr = 8'd0;
    logic [CODE_W-1:0] loop_code = 8'hA5;
    logic [15:0]       settle_len = 16'd0;
    logic [CODE_W-1:0] vco_code;
    logic [N_CLK-1:0]  clk_en;
    logic              lol_alarm, cal_active, cal_done, cal_fail, tuned;
    int                n_chk = 0, n_bad = 0, cyc = 0;

    assign tuned = tune_en && (vco_code >= thr);

    pll_cal_seq #(.CODE_W(CODE_W), .SETTLE_W(16), .N_CLK(N_CLK)) i_pll_cal_seq (
        .clk(clk), .rst_n(rst_n), .por_req(por_req), .soft_req(soft_req),
        .sig_lost(sig_lost), .lock_lost(lock_lost), .tuned(tuned),
        .loop_code(loop_code), .settle_len(settle_len), .vco_code(vco_code),
        .clk_en(clk_en), .lol_alarm(lol_alarm), .cal_active(cal_active),
        .cal_done(cal_done), .cal_fail(cal_fail)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Walk one calibration from a request raised at the last negedge.
    // Request lines (except lock_lost) are cleared after the first edge;
    // sig_lost/lock_lost are pulsed at the given cycle counts when >= 0.
    task automatic run_cal(input int max, input int los_a, input int los_b, input int lol_at,
                           output int n, output int leak, output int idle, output int last);
        n = 0; leak = 0; idle = 0; last = -1;
        while (n < max) begin
            @(posedge clk); n++;
            @(negedge clk);
            por_req = 1'b0; soft_req = 1'b0;
            sig_lost = (n == los_a) || (n == los_b);
            if (lol_at >= 0) lock_lost = (n == lol_at);
            if (cal_done) break;
            if (clk_en != '0 || lol_alarm) leak++;
            if (!cal_active) idle++;
            else last = int'(vco_code);
        end
    endtask

    initial begin
        int n, leak, idle, last;
        // Reset values.
        lock_lost = 1'b1;
        thr = 8'd3; settle_len = 16'd2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 clk_en in reset", int'(clk_en), 0);
        chk("R1 cal_done in reset", int'(cal_done), 0);
        chk("R1 cal_fail in reset", int'(cal_fail), 0);
        chk("R1 lol_alarm in reset", int'(lol_alarm), 0);
        // Power-up calibration with lock_lost held high.
        rst_n = 1'b1;
        run_cal(400, -1, -1, -1, n, leak, idle, last);
        chk("R1/R3 power-up latency", n, 9);
        chk("R4 gating during power-up cal", leak, 0);
        chk("R4 cal_active during power-up cal", idle, 0);
        chk("R2 held code", last, 3);
        chk("R5 clk_en in run", int'(clk_en), 15);
        chk("R5 vco_code follows loop", int'(vco_code), 165);
        chk("R5 alarm follows lock_lost", int'(lol_alarm), 1);
        @(negedge clk);
        chk("R6 done pulse width", int'(cal_done), 0);
        lock_lost = 1'b0;
        #1 chk("R5 alarm low", int'(lol_alarm), 0);

        // Table of thresholds and settle lengths, each started by a soft request.
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            thr = 8'(VEC[i][0]); settle_len = 16'(VEC[i][1]);
            soft_req = 1'b1;
            run_cal(400, -1, -1, -1, n, leak, idle, last);
            chk("R3 latency row", n, VEC[i][2]);
            chk("R2 held code row", last, VEC[i][0]);
            chk("R4 gating row", leak, 0);
        end

        // R7: lock loss in normal operation restarts calibration.
        @(negedge clk);
        thr = 8'd5; settle_len = 16'd3;
        lock_lost = 1'b1;
        run_cal(400, -1, -1, -1, n, leak, idle, last);
        chk("R7 lock-loss restart latency", n, 12);
        chk("R4 alarm masked during restart", leak, 0);
        @(negedge clk); lock_lost = 1'b0;

        // R8: two signal-loss edges mid-calibration give exactly one more pass.
        @(negedge clk);
        soft_req = 1'b1;
        run_cal(400, 4, 8, -1, n, leak, idle, last);
        chk("R8 pending single extra pass", n, 23);
        chk("R8 stays active between passes", idle, 0);

        // R9: a lock-loss edge mid-calibration requests nothing.
        @(negedge clk);
        por_req = 1'b1;
        run_cal(400, -1, -1, 4, n, leak, idle, last);
        chk("R9 lock loss ignored during cal", n, 12);

        // R10: no code matches.
        @(negedge clk);
        tune_en = 1'b0;
        soft_req = 1'b1;
        for (int k = 1; k <= 258; k++) begin
            @(posedge clk);
            @(negedge clk);
            soft_req = 1'b0;
            if (k == 257) chk("R10 fail not early", int'(cal_fail), 0);
            if (k == 258) chk("R10 fail flag", int'(cal_fail), 1);
        end
        lock_lost = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10 lock loss ignored when failed", int'(cal_active), 0);
        chk("R10 clocks held off", int'(clk_en), 0);
        chk("R10 still failed", int'(cal_fail), 1);
        lock_lost = 1'b0;
        tune_en = 1'b1; thr = 8'd2; settle_len = 16'd1;
        @(negedge clk);
        sig_lost = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10 fail cleared by request", int'(cal_fail), 0);
        chk("R10 restart active", int'(cal_active), 1);
        run_cal(400, -1, -1, -1, n, leak, idle, last);
        chk("R10 recovery latency", n + 1, 7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule